// File: doc/BRIEF.md
# Edge-Selecting Timestamp Merger

This block turns a coarse receive timestamp into a fine one. Upstream logic takes two snapshots of a free-running cycle counter when a frame arrives, one on each edge of the reference clock. A phase detector separately measures where the receive clock sits inside the reference period, as a value in picoseconds. The merger picks the snapshot that cannot be corrupted by a clock-crossing race and corrects it by one whole cycle where needed. It then joins the result with the sub-cycle remainder. The output is one timestamp, given as a cycle count plus picoseconds.

The race is only a risk while the measured phase is close to a calibrated transition phase. That phase is supplied on an input and must stay stable while data flows. Close to that point the falling-edge snapshot is used; elsewhere the rising-edge one is used. The cycle correction and the borrow on a negative remainder place the step in the coarse count exactly at the transition phase. The output therefore moves smoothly as the phase sweeps through the transition. The work is split over three registered stages, and a new input may be accepted on every clock.

Top module: `ts_merge_unit`

## Requirements
- R1: With the wrapped distance between phase and transition phase at most TREF_PS/4 (2000 ps by default, both ends included), the falling-edge count is the one used.
- R2: With that wrapped distance above TREF_PS/4 and below TREF_PS minus TREF_PS/4, the rising-edge count is the one used.
- R3: The wrapped distance is (phase − transition) taken modulo TREF_PS. A phase just below the transition (for example 200 ps against 1000 ps) is therefore near. A phase of 7999 ps against a transition of 0 ps is also near.
- R4: When phase ≥ transition phase, the selected count is raised by one cycle; otherwise it is left unchanged.
- R5: The picosecond output equals phase − transition when that is not negative, and phase − transition + TREF_PS otherwise, so it always lies in [0, TREF_PS).
- R6: The cycle output stays below CYC_MOD (125000000 by default); raising count CYC_MOD−1 by one gives 0.
- R7: Each input accepted with in_valid high yields exactly one out_valid pulse, with its result, after three rising edges counting the accepting edge. Inputs may arrive on consecutive cycles, and no pulse appears without an input.
- R8: While rst_n is low, out_valid, out_cycles and out_ps are 0, and inputs already in the pipeline are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| rise_cyc | input | CYC_W | Counter snapshot taken on the rising edge |
| fall_cyc | input | CYC_W | Counter snapshot taken on the falling edge |
| phase_ps | input | PS_W | Measured phase in picoseconds, [0, TREF_PS) |
| trans_ps | input | PS_W | Calibrated transition phase in picoseconds |
| out_valid | output | 1 | Result strobe |
| out_cycles | output | CYC_W | Merged whole-cycle count |
| out_ps | output | PS_W | Merged picosecond remainder |

## Verification
Each result is due on the outputs after the third rising edge, counting the edge that samples in_valid high. The bench drives inputs on falling edges and reads outputs on falling edges. In the streaming run, the result of vector k is therefore checked at the falling edge that comes three falling edges after vector k was driven. Around an isolated input, the bench also checks that out_valid is low one falling edge before the due point and one falling edge after it. After a reset that lands while data is in flight, the bench checks that no late pulse leaks out over the next four cycles.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
   localparam int unsigned DEF_CYC_W   = 27;
   localparam int unsigned DEF_CYC_MOD = 125000000;
   localparam int unsigned DEF_PS_W    = 13;
   localparam int unsigned DEF_TREF_PS = 8000;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;
endpackage

// File: rtl/tsm_edge_pick.sv
module tsm_edge_pick
   import tsm_pkg::*;
#(
   parameter int unsigned CYC_W    = DEF_CYC_W,
   parameter int unsigned PS_W     = DEF_PS_W,
   parameter int unsigned TREF_PS  = DEF_TREF_PS,
   parameter bit          WIN_INCL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [CYC_W-1:0] rise_cyc,
   input  logic [CYC_W-1:0] fall_cyc,
   input  logic [PS_W-1:0]  phase_ps,
   input  logic [PS_W-1:0]  trans_ps,
   output logic             s1_valid,
   output logic [CYC_W-1:0] s1_coarse,
   output logic             s1_ahead,
   output logic [PS_W:0]    s1_fine
);
   localparam int unsigned SW  = PS_W + 1;
   localparam int unsigned QTR = TREF_PS / 4;
   localparam logic [SW-1:0]   TREF_X = SW'(TREF_PS);
   localparam logic [PS_W-1:0] LO_LIM = PS_W'(QTR);
   localparam logic [PS_W-1:0] HI_LIM = PS_W'(TREF_PS - QTR);

   logic [SW-1:0]   diff;
   logic [SW-1:0]   diff_wrap;
   logic [PS_W-1:0] wdist;
   logic            near;
   edge_sel_e       pick;

   assign diff      = {1'b0, phase_ps} - {1'b0, trans_ps};
   assign diff_wrap = diff + TREF_X;
   assign wdist     = diff[SW-1] ? diff_wrap[PS_W-1:0] : diff[PS_W-1:0];

   generate
      if (WIN_INCL) begin : g_win_closed
         assign near = (wdist <= LO_LIM) || (wdist >= HI_LIM);
      end else begin : g_win_open
         assign near = (wdist < LO_LIM) || (wdist > HI_LIM);
      end
   endgenerate

   assign pick = near ? EDGE_FALL : EDGE_RISE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_coarse <= '0;
         s1_ahead  <= 1'b0;
         s1_fine   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_coarse <= (pick == EDGE_FALL) ? fall_cyc : rise_cyc;
            s1_ahead  <= (phase_ps >= trans_ps);
            s1_fine   <= diff;
         end
      end
   end

   // R7: an accepted input always enters the first stage
   a_r7_stage1_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);

   // R1 / R2: with equal snapshots the choice of edge cannot change the count
   a_r1_equal_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (rise_cyc == fall_cyc)) |=> (s1_coarse == $past(rise_cyc)));
endmodule

// File: rtl/tsm_cycle_step.sv
module tsm_cycle_step
   import tsm_pkg::*;
#(
   parameter int unsigned CYC_W   = DEF_CYC_W,
   parameter int unsigned CYC_MOD = DEF_CYC_MOD,
   parameter int unsigned PS_W    = DEF_PS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s1_valid,
   input  logic [CYC_W-1:0] s1_coarse,
   input  logic             s1_ahead,
   input  logic [PS_W:0]    s1_fine,
   output logic             s2_valid,
   output logic [CYC_W-1:0] s2_cyc,
   output logic [PS_W:0]    s2_fine
);
   localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CYC_MOD - 1);
   localparam bit POW2_MOD = (64'(CYC_MOD) == (64'd1 << CYC_W));

   logic [CYC_W-1:0] bumped;

   generate
      if (POW2_MOD) begin : g_wrap_natural
         assign bumped = s1_coarse + 1'b1;
      end else begin : g_wrap_compare
         assign bumped = (s1_coarse == LAST_CYC) ? '0 : s1_coarse + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_cyc   <= '0;
         s2_fine  <= '0;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) begin
            s2_cyc  <= s1_ahead ? bumped : s1_coarse;
            s2_fine <= s1_fine;
         end
      end
   end

   // R4: the correction is either nothing or exactly one (wrapped) cycle
   a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> ((s2_cyc == $past(s1_coarse)) || (s2_cyc == $past(bumped))));

   a_r7_stage2_follows: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> s2_valid);
endmodule

// File: rtl/tsm_fine_fold.sv
module tsm_fine_fold
   import tsm_pkg::*;
#(
   parameter int unsigned CYC_W   = DEF_CYC_W,
   parameter int unsigned PS_W    = DEF_PS_W,
   parameter int unsigned TREF_PS = DEF_TREF_PS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s2_valid,
   input  logic [CYC_W-1:0] s2_cyc,
   input  logic [PS_W:0]    s2_fine,
   output logic             out_valid,
   output logic [CYC_W-1:0] out_cycles,
   output logic [PS_W-1:0]  out_ps
);
   localparam logic [PS_W:0]   TREF_X = (PS_W + 1)'(TREF_PS);
   localparam logic [PS_W-1:0] TREF_N = PS_W'(TREF_PS);

   logic [PS_W:0]   borrowed;
   logic [PS_W-1:0] folded;

   assign borrowed = s2_fine + TREF_X;
   assign folded   = s2_fine[PS_W] ? borrowed[PS_W-1:0] : s2_fine[PS_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_cycles <= '0;
         out_ps     <= '0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) begin
            out_cycles <= s2_cyc;
            out_ps     <= folded;
         end
      end
   end

   // R5: the remainder never reaches a full period
   a_r5_ps_below_period: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ps < TREF_N));

   a_r7_stage3_follows: assert property (@(posedge clk) disable iff (!rst_n)
      s2_valid |=> out_valid);
endmodule

// File: rtl/ts_merge_unit.sv
module ts_merge_unit
   import tsm_pkg::*;
#(
   parameter int unsigned CYC_W    = DEF_CYC_W,
   parameter int unsigned CYC_MOD  = DEF_CYC_MOD,
   parameter int unsigned PS_W     = DEF_PS_W,
   parameter int unsigned TREF_PS  = DEF_TREF_PS,
   parameter bit          WIN_INCL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [CYC_W-1:0] rise_cyc,
   input  logic [CYC_W-1:0] fall_cyc,
   input  logic [PS_W-1:0]  phase_ps,
   input  logic [PS_W-1:0]  trans_ps,
   output logic             out_valid,
   output logic [CYC_W-1:0] out_cycles,
   output logic [PS_W-1:0]  out_ps
);
   localparam logic [CYC_W-1:0] MOD_N = CYC_W'(CYC_MOD);

   generate
      if (64'(TREF_PS) >= (64'd1 << PS_W)) begin : g_bad_ps_width
         $error("TREF_PS does not fit in PS_W bits");
      end
      if (64'(CYC_MOD) > (64'd1 << CYC_W)) begin : g_bad_cyc_width
         $error("CYC_MOD does not fit in CYC_W bits");
      end
      if (TREF_PS < 4) begin : g_bad_period
         $error("TREF_PS too small for a quarter-period window");
      end
   endgenerate

   logic             s1_valid;
   logic [CYC_W-1:0] s1_coarse;
   logic             s1_ahead;
   logic [PS_W:0]    s1_fine;
   logic             s2_valid;
   logic [CYC_W-1:0] s2_cyc;
   logic [PS_W:0]    s2_fine;

   tsm_edge_pick #(
      .CYC_W(CYC_W), .PS_W(PS_W), .TREF_PS(TREF_PS), .WIN_INCL(WIN_INCL)
   ) pick_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .rise_cyc(rise_cyc), .fall_cyc(fall_cyc),
      .phase_ps(phase_ps), .trans_ps(trans_ps),
      .s1_valid(s1_valid), .s1_coarse(s1_coarse),
      .s1_ahead(s1_ahead), .s1_fine(s1_fine)
   );

   tsm_cycle_step #(
      .CYC_W(CYC_W), .CYC_MOD(CYC_MOD), .PS_W(PS_W)
   ) step_i (
      .clk(clk), .rst_n(rst_n),
      .s1_valid(s1_valid), .s1_coarse(s1_coarse),
      .s1_ahead(s1_ahead), .s1_fine(s1_fine),
      .s2_valid(s2_valid), .s2_cyc(s2_cyc), .s2_fine(s2_fine)
   );

   tsm_fine_fold #(
      .CYC_W(CYC_W), .PS_W(PS_W), .TREF_PS(TREF_PS)
   ) fold_i (
      .clk(clk), .rst_n(rst_n),
      .s2_valid(s2_valid), .s2_cyc(s2_cyc), .s2_fine(s2_fine),
      .out_valid(out_valid), .out_cycles(out_cycles), .out_ps(out_ps)
   );

   // R6: the cycle count stays inside its modulus
   a_r6_cycles_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (64'(out_cycles) < 64'(MOD_N) || 64'(CYC_MOD) == (64'd1 << CYC_W)));
endmodule

// File: tb/ts_merge_unit_tb_top.sv
module ts_merge_unit_tb_top;
   localparam int NV = 12;

   localparam int unsigned V_RISE [NV] = '{100, 100, 100, 500, 500, 10, 10, 10, 10,
                                          124999999, 6, 6};
   localparam int unsigned V_FALL [NV] = '{101, 99, 99, 499, 499, 9, 9, 9, 9,
                                          124999999, 5, 5};
   localparam int unsigned V_PH   [NV] = '{6600, 7000, 1000, 4600, 4599, 7000, 200, 3000, 3001,
                                          7999, 0, 7999};
   localparam int unsigned V_TR   [NV] = '{6600, 6600, 6600, 6600, 6600, 1000, 1000, 1000, 1000,
                                          6600, 0, 0};
   localparam int unsigned E_CYC  [NV] = '{102, 100, 100, 499, 500, 10, 9, 10, 11,
                                          0, 6, 6};
   localparam int unsigned E_PS   [NV] = '{0, 400, 2400, 6000, 5999, 6000, 7200, 2000, 2001,
                                          1399, 0, 7999};

   string vtag [NV] = '{"R1 R4 R5", "R1 R4", "R2 R5", "R1 R3 edge", "R2 edge", "R1 R4",
                        "R3 R5 wrap", "R1 edge", "R2 R4 edge", "R6 wrap",
                        "R1 R4 zero", "R3 top"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [26:0] rise_cyc = '0;
   logic [26:0] fall_cyc = '0;
   logic [12:0] phase_ps = '0;
   logic [12:0] trans_ps = '0;
   logic        out_valid;
   logic [26:0] out_cycles;
   logic [12:0] out_ps;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ts_merge_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .rise_cyc(rise_cyc), .fall_cyc(fall_cyc),
      .phase_ps(phase_ps), .trans_ps(trans_ps),
      .out_valid(out_valid), .out_cycles(out_cycles), .out_ps(out_ps)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input int k);
      in_valid = 1'b1;
      rise_cyc = 27'(V_RISE[k]);
      fall_cyc = 27'(V_FALL[k]);
      phase_ps = 13'(V_PH[k]);
      trans_ps = 13'(V_TR[k]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset out_valid", longint'(out_valid), 0);
      chk("R8 reset out_cycles", longint'(out_cycles), 0);
      chk("R8 reset out_ps", longint'(out_ps), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // back-to-back stream, result k due three falling edges after drive
      for (int j = 0; j < NV + 3; j++) begin
         @(negedge clk);
         if (j >= 3) begin
            chk({vtag[j-3], " R7 valid"}, longint'(out_valid), 1);
            chk({vtag[j-3], " cycles"}, longint'(out_cycles), longint'(E_CYC[j-3]));
            chk({vtag[j-3], " ps"}, longint'(out_ps), longint'(E_PS[j-3]));
         end
         if (j < NV) drive(j);
         else in_valid = 1'b0;
      end
      @(negedge clk);
      chk("R7 no extra pulse", longint'(out_valid), 0);

      // isolated input: pulse only at the third edge
      repeat (2) @(negedge clk);
      drive(1);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7 early", longint'(out_valid), 0);
      @(negedge clk);
      chk("R7 due", longint'(out_valid), 1);
      chk("R7 due cycles", longint'(out_cycles), 100);
      chk("R7 due ps", longint'(out_ps), 400);
      @(negedge clk);
      chk("R7 late", longint'(out_valid), 0);

      // reset while an input is in flight
      @(negedge clk);
      drive(0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 in-reset valid", longint'(out_valid), 0);
      chk("R8 in-reset cycles", longint'(out_cycles), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         chk("R8 dropped in flight", longint'(out_valid), 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule